// File: doc/BRIEF.md
# Indexed-Color Display Controller Register Block

This block holds the software-visible state of an 8-bit indexed-color display controller. A host reaches it over a 32-bit word bus that carries a byte address, a write enable, write data and registered read data. It holds the display geometry, a control word, a scan-out start offset, a pointer position, a 256-entry color lookup table, a three-entry pointer color table and a 512-word pointer bitmap. The pixel pipeline reads the three tables through its own combinational lookup ports. It receives the decoded geometry, depth, blank and pointer-disable fields as plain outputs.

The geometry registers are scaled. The horizontal register stores four times the written value. The vertical register stores half of the written value. Both scale back when read. The pixel depth comes from a 3-bit control field through a fixed table. Writes to the video-timing registers are accepted and discarded. An interrupt line rises on a one-cycle frame pulse from the timing logic and drops on any bus write.

Clearing the tables is done by a two-state sweep machine with the states SWEEP and READY. Hardware reset enters SWEEP, and so does a write to the soft-reset address taken in READY. The machine zeroes one entry of each table per cycle. The transition SWEEP→READY happens after the last entry. The transition READY→SWEEP is taken on a soft-reset write. While the machine is in SWEEP, bus writes change no state except the interrupt.

Top module: `fbctl_regs`

## Requirements
- R1: `bus_rdata` shows, one cycle after an address is presented, the readable register at that address. Readable registers are horizontal (0x118), vertical (0x300 is control, 0x150 is vertical), control (0x300), pointer colors and pointer bitmap. Every other address, including the color table, 0x400 and 0x638, reads 0.
- R2: A write of v to 0x118 sets `width` to v·4, truncated to 32 bits. A read of 0x118 returns `width`/4.
- R3: A write of v to 0x150 sets `height` to floor(v/2). A read of 0x150 returns `height`·2.
- R4: The control word at 0x300 is stored and read back in full. `depth` comes from control bits 22:20 as follows: 0→1, 1→2, 2→4, 3→8, 4→15, 5→16, 6→0 and 7→0. `blank` is bit 10 and `cursor_off` is bit 23.
- R5: A write to 0x800+8·i, for i in 0..255, stores wdata[23:0] as {red, green, blue} in color entry i. `pal_rgb` returns the entry selected by `pal_idx`.
- R6: A write to 0x508+8·i, for i in 0..2, stores wdata[23:0] in pointer color i. That entry reads back on the bus with bits 31:24 zero, and `cpal_rgb` returns it for `cpal_idx` = i.
- R7: A write to 0x1000+8·i, for i in 0..511, stores wdata[15:0] in bitmap word i. A bus read returns that word zero-extended, and `pat_word` returns it for `pat_idx` = i.
- R8: A write to 0x400 sets `top_offset` and a write to 0x638 sets `cursor_pos`, each to the full 32-bit value.
- R9: Writes to 0x000, 0x108–0x148 and 0x158–0x170 (every 8 bytes), 0x200, and any undefined address change no register and no table.
- R10: A `frame_tick` raises `irq` on the next cycle. A bus write to any address lowers it on the next cycle. When both occur in the same cycle, the write wins.
- R11: A write to 0x100000 clears width, height, control, start offset and pointer position on the next cycle and lowers `irq`. The sweep machine then spends 512 cycles in SWEEP zeroing all tables, and it ignores bus writes during that time. Hardware reset runs the same sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 21 | Byte address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| frame_tick | input | 1 | One-cycle frame pulse |
| irq | output | 1 | Frame interrupt |
| pal_idx | input | 8 | Color table lookup index |
| pal_rgb | output | 24 | Color table entry |
| cpal_idx | input | 2 | Pointer color lookup index |
| cpal_rgb | output | 24 | Pointer color entry, 0 for index 3 |
| pat_idx | input | 9 | Pointer bitmap lookup index |
| pat_word | output | 16 | Pointer bitmap word |
| width | output | 32 | Active width in pixels |
| height | output | 32 | Active height in lines |
| depth | output | 5 | Decoded bits per pixel |
| blank | output | 1 | Forced blank |
| cursor_off | output | 1 | Pointer disabled |
| top_offset | output | 32 | Scan-out start offset |
| cursor_pos | output | 32 | Pointer position word |

## Verification
The assertions assume that `bus_addr`, `bus_we` and `frame_tick` are never unknown after reset. The geometry-scaling properties also assume the sweep has finished, so they look only at writes accepted while the block is ready. The stimulus changes every input on the falling edge. It waits out the 512-cycle sweep after each reset before it relies on table contents. It places its deliberate writes during a sweep only where their rejection is the thing being checked.

// File: rtl/fbctl_pkg.sv
package fbctl_pkg;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_IGNORE,
        RG_HDISP,
        RG_VDISP,
        RG_CTRL,
        RG_TOP,
        RG_CPOS,
        RG_CPAL,
        RG_PAL,
        RG_PAT,
        RG_SRST
    } region_e;

    typedef enum logic {
        ST_SWEEP,
        ST_READY
    } sweep_state_e;

    localparam logic [31:0] OFS_HDISP = 32'h0000_0118;
    localparam logic [31:0] OFS_VDISP = 32'h0000_0150;
    localparam logic [31:0] OFS_CTRL  = 32'h0000_0300;
    localparam logic [31:0] OFS_TOP   = 32'h0000_0400;
    localparam logic [31:0] OFS_CPAL  = 32'h0000_0508;
    localparam logic [31:0] OFS_CPOS  = 32'h0000_0638;
    localparam logic [31:0] OFS_PAL   = 32'h0000_0800;
    localparam logic [31:0] OFS_PAT   = 32'h0000_1000;
    localparam logic [31:0] OFS_SRST  = 32'h0010_0000;

    localparam int CTRL_BLANK_BIT  = 10;
    localparam int CTRL_NOCURS_BIT = 23;
    localparam int CTRL_DEPTH_LSB  = 20;

    function automatic logic [4:0] depth_of(input logic [2:0] code);
        logic [4:0] d;
        case (code)
            3'd0:    d = 5'd1;
            3'd1:    d = 5'd2;
            3'd2:    d = 5'd4;
            3'd3:    d = 5'd8;
            3'd4:    d = 5'd15;
            3'd5:    d = 5'd16;
            default: d = 5'd0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/fbctl_decode.sv
module fbctl_decode
    import fbctl_pkg::*;
#(
    parameter int ADDR_W       = 21,
    parameter int PAL_ENTRIES  = 256,
    parameter int CPAL_ENTRIES = 3,
    parameter int PAT_WORDS    = 512,
    parameter int IDX_W        = 9
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [31:0] CPAL_END = OFS_CPAL + 32'(8 * CPAL_ENTRIES);
    localparam logic [31:0] PAL_END  = OFS_PAL + 32'(8 * PAL_ENTRIES);
    localparam logic [31:0] PAT_END  = OFS_PAT + 32'(8 * PAT_WORDS);

    logic [31:0] a;

    always_comb begin
        a      = 32'(addr);
        region = RG_NONE;
        idx    = '0;
        if (a >= OFS_CPAL && a < CPAL_END) begin
            region = RG_CPAL;
            idx    = IDX_W'((a - OFS_CPAL) >> 3);
        end else if (a >= OFS_PAL && a < PAL_END) begin
            region = RG_PAL;
            idx    = IDX_W'((a - OFS_PAL) >> 3);
        end else if (a >= OFS_PAT && a < PAT_END) begin
            region = RG_PAT;
            idx    = IDX_W'((a - OFS_PAT) >> 3);
        end else begin
            case (a)
                OFS_HDISP: region = RG_HDISP;
                OFS_VDISP: region = RG_VDISP;
                OFS_CTRL:  region = RG_CTRL;
                OFS_TOP:   region = RG_TOP;
                OFS_CPOS:  region = RG_CPOS;
                OFS_SRST:  region = RG_SRST;
                32'h000, 32'h108, 32'h110, 32'h120, 32'h128,
                32'h130, 32'h138, 32'h140, 32'h148, 32'h158,
                32'h160, 32'h168, 32'h170, 32'h200:
                           region = RG_IGNORE;
                default:   region = RG_NONE;
            endcase
        end
    end

endmodule

// File: rtl/fbctl_sweep_fsm.sv
module fbctl_sweep_fsm
    import fbctl_pkg::*;
#(
    parameter int SPAN  = 512,
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srst_req,
    output logic             sweep_en,
    output logic [IDX_W-1:0] sweep_idx,
    output logic             ready
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(SPAN - 1);

    sweep_state_e     state_q, state_d;
    logic [IDX_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SWEEP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_SWEEP: begin
                if (cnt_q == LAST) begin
                    state_d = ST_READY;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_READY: begin
                cnt_d = '0;
                if (srst_req) state_d = ST_SWEEP;
            end
        endcase
    end

    always_comb begin
        sweep_en  = (state_q == ST_SWEEP);
        ready     = (state_q == ST_READY);
        sweep_idx = cnt_q;
    end

endmodule

// File: rtl/fbctl_stores.sv
module fbctl_stores #(
    parameter int PAL_ENTRIES  = 256,
    parameter int CPAL_ENTRIES = 3,
    parameter int PAT_WORDS    = 512,
    parameter int IDX_W        = 9,
    localparam int PAL_AW      = $clog2(PAL_ENTRIES),
    localparam int CPAL_AW     = $clog2(CPAL_ENTRIES),
    localparam int PAT_AW      = $clog2(PAT_WORDS)
) (
    input  logic               clk,
    input  logic               sweep_en,
    input  logic [IDX_W-1:0]   sweep_idx,
    input  logic               wr_pal,
    input  logic               wr_cpal,
    input  logic               wr_pat,
    input  logic [IDX_W-1:0]   bus_idx,
    input  logic [23:0]        wr_data,
    input  logic [PAL_AW-1:0]  pal_idx,
    output logic [23:0]        pal_rgb,
    input  logic [CPAL_AW-1:0] cpal_idx,
    output logic [23:0]        cpal_rgb,
    input  logic [PAT_AW-1:0]  pat_idx,
    output logic [15:0]        pat_word,
    output logic [23:0]        bus_cpal,
    output logic [15:0]        bus_pat
);
    logic [23:0] pal_mem  [PAL_ENTRIES];
    logic [15:0] pat_mem  [PAT_WORDS];
    logic [23:0] cpal_mem [CPAL_ENTRIES];

    always_ff @(posedge clk) begin
        if (sweep_en) begin
            if (32'(sweep_idx) < PAL_ENTRIES)
                pal_mem[sweep_idx[PAL_AW-1:0]] <= '0;
            if (32'(sweep_idx) < PAT_WORDS)
                pat_mem[sweep_idx[PAT_AW-1:0]] <= '0;
        end else begin
            if (wr_pal) pal_mem[bus_idx[PAL_AW-1:0]] <= wr_data;
            if (wr_pat) pat_mem[bus_idx[PAT_AW-1:0]] <= wr_data[15:0];
        end
    end

    for (genvar g = 0; g < CPAL_ENTRIES; g++) begin : g_cpal
        always_ff @(posedge clk) begin
            if (sweep_en) begin
                if (32'(sweep_idx) == g) cpal_mem[g] <= '0;
            end else if (wr_cpal && 32'(bus_idx) == g) begin
                cpal_mem[g] <= wr_data;
            end
        end
    end

    always_comb begin
        pal_rgb  = pal_mem[pal_idx];
        pat_word = pat_mem[pat_idx];
        bus_pat  = pat_mem[bus_idx[PAT_AW-1:0]];
        cpal_rgb = (32'(cpal_idx) < CPAL_ENTRIES) ? cpal_mem[cpal_idx] : '0;
        bus_cpal = (32'(bus_idx) < CPAL_ENTRIES) ? cpal_mem[bus_idx[CPAL_AW-1:0]] : '0;
    end

endmodule

// File: rtl/fbctl_regs.sv
module fbctl_regs
    import fbctl_pkg::*;
#(
    parameter int ADDR_W       = 21,
    parameter int PAL_ENTRIES  = 256,
    parameter int CPAL_ENTRIES = 3,
    parameter int PAT_WORDS    = 512,
    localparam int PAL_AW      = $clog2(PAL_ENTRIES),
    localparam int CPAL_AW     = $clog2(CPAL_ENTRIES),
    localparam int PAT_AW      = $clog2(PAT_WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               frame_tick,
    output logic               irq,
    input  logic [PAL_AW-1:0]  pal_idx,
    output logic [23:0]        pal_rgb,
    input  logic [CPAL_AW-1:0] cpal_idx,
    output logic [23:0]        cpal_rgb,
    input  logic [PAT_AW-1:0]  pat_idx,
    output logic [15:0]        pat_word,
    output logic [31:0]        width,
    output logic [31:0]        height,
    output logic [4:0]         depth,
    output logic               blank,
    output logic               cursor_off,
    output logic [31:0]        top_offset,
    output logic [31:0]        cursor_pos
);
    localparam int SPAN  = (PAL_ENTRIES > PAT_WORDS) ? PAL_ENTRIES : PAT_WORDS;
    localparam int IDX_W = $clog2(SPAN);

    region_e          region;
    logic [IDX_W-1:0] bus_idx;
    logic             sweep_en;
    logic [IDX_W-1:0] sweep_idx;
    logic             ready;
    logic             wr_ok;
    logic             srst_req;
    logic [23:0]      bus_cpal;
    logic [15:0]      bus_pat;
    logic [31:0]      rd_mux;

    logic [31:0] width_q, height_q, ctrl_q, top_q, cpos_q, rdata_q;
    logic        irq_q;

    fbctl_decode #(
        .ADDR_W(ADDR_W), .PAL_ENTRIES(PAL_ENTRIES),
        .CPAL_ENTRIES(CPAL_ENTRIES), .PAT_WORDS(PAT_WORDS), .IDX_W(IDX_W)
    ) u_decode (
        .addr(bus_addr), .region(region), .idx(bus_idx)
    );

    assign srst_req = bus_we && (region == RG_SRST);
    assign wr_ok    = bus_we && ready;

    fbctl_sweep_fsm #(.SPAN(SPAN), .IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .srst_req(srst_req),
        .sweep_en(sweep_en), .sweep_idx(sweep_idx), .ready(ready)
    );

    fbctl_stores #(
        .PAL_ENTRIES(PAL_ENTRIES), .CPAL_ENTRIES(CPAL_ENTRIES),
        .PAT_WORDS(PAT_WORDS), .IDX_W(IDX_W)
    ) u_stores (
        .clk(clk), .sweep_en(sweep_en), .sweep_idx(sweep_idx),
        .wr_pal(wr_ok && region == RG_PAL),
        .wr_cpal(wr_ok && region == RG_CPAL),
        .wr_pat(wr_ok && region == RG_PAT),
        .bus_idx(bus_idx), .wr_data(bus_wdata[23:0]),
        .pal_idx(pal_idx), .pal_rgb(pal_rgb),
        .cpal_idx(cpal_idx), .cpal_rgb(cpal_rgb),
        .pat_idx(pat_idx), .pat_word(pat_word),
        .bus_cpal(bus_cpal), .bus_pat(bus_pat)
    );

    always_comb begin
        case (region)
            RG_HDISP: rd_mux = width_q >> 2;
            RG_VDISP: rd_mux = height_q << 1;
            RG_CTRL:  rd_mux = ctrl_q;
            RG_CPAL:  rd_mux = {8'h00, bus_cpal};
            RG_PAT:   rd_mux = {16'h0000, bus_pat};
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            width_q  <= '0;
            height_q <= '0;
            ctrl_q   <= '0;
            top_q    <= '0;
            cpos_q   <= '0;
            irq_q    <= 1'b0;
            rdata_q  <= '0;
        end else begin
            if (bus_we)          irq_q <= 1'b0;
            else if (frame_tick) irq_q <= 1'b1;

            if (srst_req) begin
                width_q  <= '0;
                height_q <= '0;
                ctrl_q   <= '0;
                top_q    <= '0;
                cpos_q   <= '0;
            end else if (wr_ok) begin
                case (region)
                    RG_HDISP: width_q  <= bus_wdata << 2;
                    RG_VDISP: height_q <= bus_wdata >> 1;
                    RG_CTRL:  ctrl_q   <= bus_wdata;
                    RG_TOP:   top_q    <= bus_wdata;
                    RG_CPOS:  cpos_q   <= bus_wdata;
                    default:  ;
                endcase
            end
            rdata_q <= rd_mux;
        end
    end

    assign bus_rdata  = rdata_q;
    assign irq        = irq_q;
    assign width      = width_q;
    assign height     = height_q;
    assign depth      = depth_of(ctrl_q[CTRL_DEPTH_LSB +: 3]);
    assign blank      = ctrl_q[CTRL_BLANK_BIT];
    assign cursor_off = ctrl_q[CTRL_NOCURS_BIT];
    assign top_offset = top_q;
    assign cursor_pos = cpos_q;

endmodule

// File: rtl/fbctl_regs_chk.sv
module fbctl_regs_chk #(
    parameter int ADDR_W = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              frame_tick,
    input logic              irq,
    input logic [31:0]       width,
    input logic [31:0]       height,
    input logic [4:0]        depth,
    input logic              blank,
    input logic              cursor_off,
    input logic [31:0]       top_offset,
    input logic [31:0]       cursor_pos,
    input logic              ready
);
    // R10: a frame pulse with no write sets the interrupt
    a_r10_tick_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_tick && !bus_we) |=> irq);

    // R10: any write lowers the interrupt, even against a pulse
    a_r10_write_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> !irq);

    // R2: horizontal scaling on write
    a_r2_width_scaled: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && ready && 32'(bus_addr) == 32'h118)
        |=> (width == ($past(bus_wdata) << 2)));

    // R3: vertical scaling on write
    a_r3_height_halved: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && ready && 32'(bus_addr) == 32'h150)
        |=> (height == ($past(bus_wdata) >> 1)));

    // R4: depth stays inside the table
    a_r4_depth_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (depth == 5'd0 || depth == 5'd1 || depth == 5'd2 || depth == 5'd4 ||
         depth == 5'd8 || depth == 5'd15 || depth == 5'd16));

    // R11: soft reset clears the scalar state
    a_r11_srst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && 32'(bus_addr) == 32'h10_0000)
        |=> (width == 0 && height == 0 && !blank && !cursor_off &&
             top_offset == 0 && cursor_pos == 0 && !irq));

    // R1: an undefined address reads as zero
    a_r1_undef_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(bus_addr) == 32'h404) |=> (bus_rdata == 32'h0));

endmodule

bind fbctl_regs fbctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_tick(frame_tick),
    .irq(irq), .width(width), .height(height), .depth(depth),
    .blank(blank), .cursor_off(cursor_off), .top_offset(top_offset),
    .cursor_pos(cursor_pos), .ready(ready)
);

// File: tb/fbctl_regs_bench.sv
`timescale 1ns/1ps
module fbctl_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [20:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        frame_tick = 1'b0;
    logic        irq;
    logic [7:0]  pal_idx = '0;
    logic [23:0] pal_rgb;
    logic [1:0]  cpal_idx = '0;
    logic [23:0] cpal_rgb;
    logic [8:0]  pat_idx = '0;
    logic [15:0] pat_word;
    logic [31:0] width, height, top_offset, cursor_pos;
    logic [4:0]  depth;
    logic        blank, cursor_off;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    fbctl_regs u_fbctl_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_tick(frame_tick),
        .irq(irq), .pal_idx(pal_idx), .pal_rgb(pal_rgb), .cpal_idx(cpal_idx),
        .cpal_rgb(cpal_rgb), .pat_idx(pat_idx), .pat_word(pat_word),
        .width(width), .height(height), .depth(depth), .blank(blank),
        .cursor_off(cursor_off), .top_offset(top_offset), .cursor_pos(cursor_pos)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        bus_addr = 21'(a); bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        bus_addr = 21'(a);
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [23:0] cval(input int i);
        return {8'(i), ~8'(i), 8'(i) ^ 8'h5A};
    endfunction

    function automatic logic [15:0] pval(input int i);
        return 16'(i * 40503) ^ 16'h5A5A;
    endfunction

    function automatic logic [4:0] dexp(input int c);
        if (c < 4) return 5'(1 << c);
        if (c == 4) return 5'd15;
        if (c == 5) return 5'd16;
        return 5'd0;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        logic [31:0] vals [5];
        vals = '{32'h0, 32'h1, 32'h12345, 32'h3FFF_FFFF, 32'hFFFF_FFFF};
        idle(3);
        rst_n = 1'b1;
        idle(520);

        // R11 reset state and hardware-reset sweep
        chk("R11 irq", 32'(irq), 0);
        rd(32'h118, r); chk("R11 width read", r, 0);
        rd(32'h300, r); chk("R11 ctrl read", r, 0);
        chk("R4 reset depth", 32'(depth), 1);
        for (int i = 0; i < 256; i++) begin
            pal_idx = 8'(i); #1; chk("R11 pal cleared", 32'(pal_rgb), 0);
        end
        for (int i = 0; i < 512; i++) begin
            pat_idx = 9'(i); #1; chk("R11 pat cleared", 32'(pat_word), 0);
        end
        @(negedge clk);

        // R2 horizontal scaling
        foreach (vals[k]) begin
            wr(32'h118, vals[k]);
            chk("R2 width", width, vals[k] << 2);
            rd(32'h118, r); chk("R2 read", r, (vals[k] << 2) >> 2);
        end

        // R3 vertical scaling
        foreach (vals[k]) begin
            wr(32'h150, vals[k]);
            chk("R3 height", height, vals[k] >> 1);
            rd(32'h150, r); chk("R3 read", r, (vals[k] >> 1) << 1);
        end

        // R4 depth table and flags
        for (int c = 0; c < 8; c++) begin
            logic [31:0] w;
            w = (32'(c) << 20) | (32'(c & 1) << 10) | (32'((c >> 1) & 1) << 23) | 32'h0F0;
            wr(32'h300, w);
            chk("R4 depth", 32'(depth), 32'(dexp(c)));
            chk("R4 blank", 32'(blank), 32'(c & 1));
            chk("R4 cursor_off", 32'(cursor_off), 32'((c >> 1) & 1));
            rd(32'h300, r); chk("R4 readback", r, w);
        end

        // R5 color table sweep
        for (int i = 0; i < 256; i++) wr(32'h800 + 32'(8 * i), {8'hFF, cval(i)});
        for (int i = 0; i < 256; i++) begin
            pal_idx = 8'(i); #1; chk("R5 pal port", 32'(pal_rgb), 32'(cval(i)));
        end
        @(negedge clk);
        rd(32'h808, r); chk("R1 color table reads zero", r, 0);

        // R6 pointer colors
        for (int i = 0; i < 3; i++) wr(32'h508 + 32'(8 * i), {8'hA5, cval(i + 77)});
        for (int i = 0; i < 3; i++) begin
            rd(32'h508 + 32'(8 * i), r); chk("R6 bus read", r, {8'h00, cval(i + 77)});
            cpal_idx = 2'(i); #1; chk("R6 port", 32'(cpal_rgb), 32'(cval(i + 77)));
            @(negedge clk);
        end
        cpal_idx = 2'd3; #1; chk("R6 index 3 zero", 32'(cpal_rgb), 0);
        @(negedge clk);

        // R7 pointer bitmap sweep
        for (int i = 0; i < 512; i++) wr(32'h1000 + 32'(8 * i), {16'hDEAD, pval(i)});
        for (int i = 0; i < 512; i++) begin
            rd(32'h1000 + 32'(8 * i), r); chk("R7 bus read", r, {16'h0, pval(i)});
            pat_idx = 9'(i); #1; chk("R7 port", 32'(pat_word), 32'(pval(i)));
        end
        @(negedge clk);

        // R8 start offset and pointer position
        wr(32'h400, 32'hCAFE_0123); chk("R8 top", top_offset, 32'hCAFE_0123);
        wr(32'h638, 32'h0040_0020); chk("R8 cpos", cursor_pos, 32'h0040_0020);
        rd(32'h400, r); chk("R1 top reads zero", r, 0);
        rd(32'h638, r); chk("R1 cpos reads zero", r, 0);

        // R9 ignored and undefined writes
        wr(32'h118, 32'h50); wr(32'h150, 32'h40); wr(32'h300, 32'h0030_0000);
        begin
            logic [31:0] ign [17];
            ign = '{32'h000, 32'h108, 32'h110, 32'h120, 32'h128, 32'h130, 32'h138,
                    32'h140, 32'h148, 32'h158, 32'h160, 32'h168, 32'h170, 32'h200,
                    32'h404, 32'h2000, 32'h17_FFFC};
            foreach (ign[k]) wr(ign[k], 32'hFFFF_FFFF);
        end
        chk("R9 width", width, 32'h140);
        chk("R9 height", height, 32'h20);
        chk("R9 depth", 32'(depth), 8);
        chk("R9 top", top_offset, 32'hCAFE_0123);
        chk("R9 cpos", cursor_pos, 32'h0040_0020);
        rd(32'h404, r); chk("R9 undefined read", r, 0);
        pal_idx = 8'd0; pat_idx = 9'd0; cpal_idx = 2'd0; #1;
        chk("R9 pal", 32'(pal_rgb), 32'(cval(0)));
        chk("R9 pat", 32'(pat_word), 32'(pval(0)));
        chk("R9 cpal", 32'(cpal_rgb), 32'(cval(77)));
        @(negedge clk);

        // R10 interrupt
        frame_tick = 1'b1; @(negedge clk); frame_tick = 1'b0;
        chk("R10 raise", 32'(irq), 1);
        idle(2); chk("R10 hold", 32'(irq), 1);
        wr(32'h404, 0); chk("R10 write clears", 32'(irq), 0);
        frame_tick = 1'b1; wr(32'h404, 0); frame_tick = 1'b0;
        chk("R10 write wins", 32'(irq), 0);
        frame_tick = 1'b1; @(negedge clk); frame_tick = 1'b0;

        // R11 soft reset
        wr(32'h10_0000, 32'h0);
        chk("R11 irq lowered", 32'(irq), 0);
        chk("R11 width", width, 0);
        chk("R11 height", height, 0);
        chk("R11 top", top_offset, 0);
        chk("R11 cpos", cursor_pos, 0);
        chk("R11 blank", 32'(blank), 0);
        wr(32'h300, 32'h0080_0400);
        wr(32'h808, 32'h00_1234);
        idle(520);
        rd(32'h300, r); chk("R11 write during sweep ignored", r, 0);
        for (int i = 0; i < 256; i++) begin
            pal_idx = 8'(i); #1; chk("R11 pal swept", 32'(pal_rgb), 0);
        end
        for (int i = 0; i < 512; i++) begin
            pat_idx = 9'(i); #1; chk("R11 pat swept", 32'(pat_word), 0);
        end
        for (int i = 0; i < 4; i++) begin
            cpal_idx = 2'(i); #1; chk("R11 cpal swept", 32'(cpal_rgb), 0);
        end
        @(negedge clk);
        wr(32'h118, 32'h10); chk("R11 ready after sweep", width, 32'h40);

        finish_run();
    end
endmodule